// File: doc/BRIEF.md
# Two-Phase Intersection Light Sequencer

This block sequences the lamps at a crossing of an east-west road and a north-south road. It holds a two-digit BCD countdown that steps once for each one-second tick enable. It gives the right of way to one road at a time. When a phase runs out, the counter reloads itself with the duration of the other phase, and a single phase flag flips to hand over the right of way. Both digits are brought out, so a display decoder outside the block can show the remaining seconds.

The lamps come from a magnitude comparison of the running count against a threshold. While the count is above the yellow threshold, the road that has the phase shows green. While the count is at or below it, that road shows yellow. The road without the phase always shows red. With the default parameters, the east-west phase runs 22 counts, the north-south phase runs 16 counts, and the last 3 counts of each phase are yellow. The tick divider and the seven-segment decoding sit outside the block. Everything runs on one clock, and the reset is synchronous and active high.

Top module: `light_sequencer`

## Requirements
- R1: In the cycle after reset is sampled high, the count reads 22 (`cntTens`=2, `cntUnits`=2). The east-west phase is active: `ewGreen` is 1 and `nsRed` is 1.
- R2: On a clock edge where `tick` is 0 and reset is low, the digits and all six lamp outputs keep their values.
- R3: On a clock edge where `tick` is 1 and the count is not 01, the count drops by exactly one in BCD. When the units digit wraps from 0 to 9, the tens digit drops by one, so 20 is followed by 19 and 10 by 09.
- R4: On a tick while the east-west phase shows count 01, the next count is 16 and the north-south phase becomes active (`nsGreen`=1, `ewRed`=1).
- R5: On a tick while the north-south phase shows count 01, the next count is 22 and the east-west phase becomes active (`ewGreen`=1, `nsRed`=1).
- R6: The active road shows yellow when the count is 3 or less and green when the count is above 3. The inactive road shows red.
- R7: Exactly one of the three lamps of each road is lit at all times, and at least one road shows red.
- R8: Both digits always hold a valid BCD value from 0 to 9, and the count never reads 00.
- R9: Reset takes priority over a tick in the same cycle. The result is the state given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-second count enable, sampled on the clock |
| ewRed | output | 1 | East-west red lamp |
| ewYellow | output | 1 | East-west yellow lamp |
| ewGreen | output | 1 | East-west green lamp |
| nsRed | output | 1 | North-south red lamp |
| nsYellow | output | 1 | North-south yellow lamp |
| nsGreen | output | 1 | North-south green lamp |
| cntTens | output | 4 | Tens digit of the remaining count, BCD |
| cntUnits | output | 4 | Units digit of the remaining count, BCD |

## Verification
Two events can fall on the same clock edge.

- **Expiry with handover.** A tick that meets count 01 must reload the other preset and flip the phase, and the lamps must hand over, all on that one edge. Long runs with `tick` held high drive the count through both expiries repeatedly. Random tick patterns then approach each expiry with idle cycles in between. The count and all six lamps are compared with a bench model after every edge.
- **Reset with a tick.** Reset is raised together with a tick. This is done both at an arbitrary count and exactly at count 01 with a tick pending. The next cycle must show the reset state and not a reload or a decrement.

// File: rtl/light_seq_pkg.sv
package light_seq_pkg;

  typedef enum logic [1:0] {
    LAMP_RED    = 2'd0,
    LAMP_YELLOW = 2'd1,
    LAMP_GREEN  = 2'd2
  } lamp_e;

  // Strobes from the control to the counter datapath
  typedef struct packed {
    logic load;    // reload a preset
    logic loadNs;  // 1: north-south preset, 0: east-west preset
    logic dec;     // decrement by one in BCD
  } strobe_t;

  localparam int NUM_ROADS = 2;
  localparam int ROAD_EW   = 0;
  localparam int ROAD_NS   = 1;

endpackage

// File: rtl/seq_bcd_counter.sv
module seq_bcd_counter
  import light_seq_pkg::*;
#(
  parameter int EW_TIME = 22,
  parameter int NS_TIME = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  strobe_t    strobes,
  output logic [3:0] tens,
  output logic [3:0] units
);

  localparam logic [3:0] EW_TENS  = 4'(EW_TIME / 10);
  localparam logic [3:0] EW_UNITS = 4'(EW_TIME % 10);
  localparam logic [3:0] NS_TENS  = 4'(NS_TIME / 10);
  localparam logic [3:0] NS_UNITS = 4'(NS_TIME % 10);

  always_ff @(posedge clk) begin
    if (rst) begin
      tens  <= EW_TENS;
      units <= EW_UNITS;
    end else if (strobes.load) begin
      tens  <= strobes.loadNs ? NS_TENS  : EW_TENS;
      units <= strobes.loadNs ? NS_UNITS : EW_UNITS;
    end else if (strobes.dec) begin
      if (units == 4'd0) begin
        units <= 4'd9;
        tens  <= tens - 4'd1;
      end else begin
        units <= units - 4'd1;
      end
    end
  end

endmodule

// File: rtl/seq_phase_ctrl.sv
module seq_phase_ctrl
  import light_seq_pkg::*;
#(
  parameter int YELLOW_TIME = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [3:0] tens,
  input  logic [3:0] units,
  output strobe_t    strobes,
  output lamp_e      lamps [NUM_ROADS]
);

  localparam logic [7:0] YELLOW_LIMIT = 8'(YELLOW_TIME);

  logic       phaseNs;
  logic [7:0] countBin;
  logic       isLast;
  logic       inYellow;

  // Magnitude of the BCD count, used for the lamp comparison
  assign countBin = ({4'b0, tens} * 8'd10) + {4'b0, units};
  assign isLast   = (countBin == 8'd1);
  assign inYellow = (countBin <= YELLOW_LIMIT);

  always_comb begin
    strobes.load   = tick && isLast;
    strobes.loadNs = !phaseNs;
    strobes.dec    = tick && !isLast;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseNs <= 1'b0;
    end else if (strobes.load) begin
      phaseNs <= !phaseNs;
    end
  end

  for (genvar r = 0; r < NUM_ROADS; r++) begin : g_road
    always_comb begin
      if (phaseNs == (r == ROAD_NS)) begin
        lamps[r] = inYellow ? LAMP_YELLOW : LAMP_GREEN;
      end else begin
        lamps[r] = LAMP_RED;
      end
    end
  end

endmodule

// File: rtl/light_sequencer.sv
module light_sequencer
  import light_seq_pkg::*;
#(
  parameter int EW_TIME     = 22,
  parameter int NS_TIME     = 16,
  parameter int YELLOW_TIME = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  output logic       ewRed,
  output logic       ewYellow,
  output logic       ewGreen,
  output logic       nsRed,
  output logic       nsYellow,
  output logic       nsGreen,
  output logic [3:0] cntTens,
  output logic [3:0] cntUnits
);

  strobe_t strobes;
  lamp_e   lamps [NUM_ROADS];

  seq_phase_ctrl #(
    .YELLOW_TIME(YELLOW_TIME)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .tens   (cntTens),
    .units  (cntUnits),
    .strobes(strobes),
    .lamps  (lamps)
  );

  seq_bcd_counter #(
    .EW_TIME(EW_TIME),
    .NS_TIME(NS_TIME)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .tens   (cntTens),
    .units  (cntUnits)
  );

  assign ewRed    = (lamps[ROAD_EW] == LAMP_RED);
  assign ewYellow = (lamps[ROAD_EW] == LAMP_YELLOW);
  assign ewGreen  = (lamps[ROAD_EW] == LAMP_GREEN);
  assign nsRed    = (lamps[ROAD_NS] == LAMP_RED);
  assign nsYellow = (lamps[ROAD_NS] == LAMP_YELLOW);
  assign nsGreen  = (lamps[ROAD_NS] == LAMP_GREEN);

endmodule

// File: rtl/light_sequencer_chk.sv
module light_sequencer_chk #(
  parameter int EW_TIME     = 22,
  parameter int NS_TIME     = 16,
  parameter int YELLOW_TIME = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       ewRed,
  input logic       ewYellow,
  input logic       ewGreen,
  input logic       nsRed,
  input logic       nsYellow,
  input logic       nsGreen,
  input logic [3:0] cntTens,
  input logic [3:0] cntUnits
);

  logic [7:0] cntVal;
  logic [5:0] lampVec;
  assign cntVal  = ({4'b0, cntTens} * 8'd10) + {4'b0, cntUnits};
  assign lampVec = {ewRed, ewYellow, ewGreen, nsRed, nsYellow, nsGreen};

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (cntVal == 8'(EW_TIME) && ewGreen && nsRed));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(cntVal) && $stable(lampVec)));

  p_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && cntVal != 8'd1) |=> (cntVal == $past(cntVal) - 8'd1));

  p_ew_to_ns_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && cntVal == 8'd1 && ewYellow) |=> (cntVal == 8'(NS_TIME) && nsGreen && ewRed));

  p_ns_to_ew_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && cntVal == 8'd1 && nsYellow) |=> (cntVal == 8'(EW_TIME) && ewGreen && nsRed));

  p_yellow_window_r6: assert property (@(posedge clk) disable iff (rst)
    (cntVal <= 8'(YELLOW_TIME)) == (ewYellow || nsYellow));

  p_one_lamp_r7: assert property (@(posedge clk) disable iff (rst)
    ($countones({ewRed, ewYellow, ewGreen}) == 1) &&
    ($countones({nsRed, nsYellow, nsGreen}) == 1) && (ewRed || nsRed));

  p_valid_bcd_r8: assert property (@(posedge clk) disable iff (rst)
    (cntTens <= 4'd9) && (cntUnits <= 4'd9) && (cntVal != 8'd0));

  p_reset_wins_r9: assert property (@(posedge clk)
    (rst && tick) |=> (cntVal == 8'(EW_TIME) && ewGreen));

endmodule

bind light_sequencer light_sequencer_chk #(
  .EW_TIME    (EW_TIME),
  .NS_TIME    (NS_TIME),
  .YELLOW_TIME(YELLOW_TIME)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .ewRed   (ewRed),
  .ewYellow(ewYellow),
  .ewGreen (ewGreen),
  .nsRed   (nsRed),
  .nsYellow(nsYellow),
  .nsGreen (nsGreen),
  .cntTens (cntTens),
  .cntUnits(cntUnits)
);

// File: tb/sim_light_sequencer.sv
`timescale 1ns/1ps
module sim_light_sequencer;

  localparam int EW_T = 22;
  localparam int NS_T = 16;
  localparam int YEL_T = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic ewRed, ewYellow, ewGreen, nsRed, nsYellow, nsGreen;
  logic [3:0] cntTens, cntUnits;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Bench model
  bit mPhaseNs = 1'b0;
  int mCount = EW_T;

  always #5 clk = ~clk;

  light_sequencer u0 (
    .clk(clk), .rst(rst), .tick(tick),
    .ewRed(ewRed), .ewYellow(ewYellow), .ewGreen(ewGreen),
    .nsRed(nsRed), .nsYellow(nsYellow), .nsGreen(nsGreen),
    .cntTens(cntTens), .cntUnits(cntUnits)
  );

  // {ewR, ewY, ewG, nsR, nsY, nsG}
  function automatic logic [5:0] expLamps(bit phaseNs, int count);
    logic [2:0] active;
    active = (count <= YEL_T) ? 3'b010 : 3'b001;
    return phaseNs ? {3'b100, active} : {active, 3'b100};
  endfunction

  function automatic logic [7:0] expDigits(int count);
    return {4'(count / 10), 4'(count % 10)};
  endfunction

  task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit r, bit t);
    string tag;
    @(negedge clk);
    rst = r;
    tick = t;
    if (r) begin
      tag = t ? "R9" : "R1";
      mPhaseNs = 1'b0;
      mCount = EW_T;
    end else if (!t) begin
      tag = "R2";
    end else if (mCount == 1) begin
      tag = mPhaseNs ? "R5" : "R4";
      mPhaseNs = !mPhaseNs;
      mCount = mPhaseNs ? NS_T : EW_T;
    end else begin
      tag = "R3,R8";
      mCount--;
    end
    @(posedge clk);
    #1;
    check({cntTens, cntUnits} == expDigits(mCount), {tag, " digits"},
          {cntTens, cntUnits}, expDigits(mCount));
    check({ewRed, ewYellow, ewGreen, nsRed, nsYellow, nsGreen} == expLamps(mPhaseNs, mCount),
          {tag, " R6,R7 lamps"},
          {2'b00, ewRed, ewYellow, ewGreen, nsRed, nsYellow, nsGreen},
          {2'b00, expLamps(mPhaseNs, mCount)});
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=50000", cycles);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    // R9: reset together with tick
    step(1'b1, 1'b1);
    // R2: idle cycles hold everything
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
    // R3/R4/R5: continuous ticks through two full cycles (20->19, 10->09)
    for (int i = 0; i < 80; i++) step(1'b0, 1'b1);
    // Random ticks with occasional reset
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 400) == 0, ($urandom % 3) == 0);
    end
    // R9: reset at count 01 with tick pending
    while (mCount != 1) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    // R5: reach north-south expiry, idle there, then tick
    for (int i = 0; i < EW_T; i++) step(1'b0, 1'b1);
    while (mCount != 1) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1);
    finishRun();
  end

endmodule